// File: doc/BRIEF.md
# Scan Response Word Packer

This block sits at the output end of a test wrapper that sends scan responses back over a functional interconnect port instead of dedicated test wires. A group of K wrapper chains shifts its responses out serially. The packer collects those bits and builds fixed-width words, one per output period, for the port.

Each word holds one slice per chain. A slice is P = floor(W/K) bits, taken from the tail cells of that chain, so the output period is P shift cycles. The W - K*P remainder positions at the top of the word carry a group of response cells that are captured in parallel when the unload of a pattern begins. These cells are valid only in the first word of that pattern. In every later word those positions are zero.

The packer moves the chains itself through a shift strobe. It raises the strobe only when the bit taken in that cycle can reach the output, so backpressure from the port stalls the chains and no response bit is lost. When the scan-out length is not a whole number of periods, the unfilled positions of the last word are zero.

Top module: `resp_packer`

## Requirements
- R1: In every word, chain c occupies bits [c*P +: P] with P = floor(W/K). Within a slice, the bit shifted out first sits at the lowest position.
- R2: One unload emits exactly ceil(SCAN_LEN/P) words. Each word except the last holds P shifted bits per chain.
- R3: The value on `rem_i` in the cycle a start is accepted appears in bits [W-1:K*P] of the first word of that pattern. Later changes to `rem_i` have no effect on that word.
- R4: Bits [W-1:K*P] are zero in every word after the first of a pattern.
- R5: When SCAN_LEN is not a multiple of P, the slice positions of the last word that receive no shifted bit are zero.
- R6: `shift_o` is raised only when the bit taken in that cycle can be kept. Over one unload the chains are shifted exactly SCAN_LEN times, whatever the pattern of `word_ready_i`.
- R7: While `word_valid_o` is high and `word_ready_i` is low, `word_valid_o` stays high and `word_o` stays unchanged in the next cycle.
- R8: A start request while an unload is in progress is ignored. After the final word of a pattern, `shift_o` stays low until the next start.
- R9: After reset, `word_valid_o`, `shift_o` and `busy_o` are low.
- R10: `shift_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin unloading one pattern. Accepted only when not busy |
| rem_i | input | max(W-K*P,1) | Remainder response cells, captured when a start is accepted |
| chain_so_i | input | K | Serial output bit of each wrapper chain, bit c from chain c |
| shift_o | output | 1 | Shift strobe to the wrapper chains. The current bits are taken this cycle |
| word_o | output | W | Packed response word |
| word_valid_o | output | 1 | `word_o` holds a word |
| word_ready_i | input | 1 | The port takes the word in this cycle |
| busy_o | output | 1 | An unload is in progress |

## Verification
The assertions take for granted that the environment holds `chain_so_i` at the chain's current tail bit and advances it only after a cycle with `shift_o` high. They also assume `word_ready_i` is a plain level with no assumed timing. The bench models each chain as an array indexed by a position that steps only on sampled shift strobes. It varies the ready level randomly, from always high to mostly low, so stalls fall both at word boundaries and inside a period. Start pulses are issued only when idle, except for one deliberate pulse in the middle of an unload that checks R8.

// File: rtl/resp_packer_pkg.sv
package resp_packer_pkg;

    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_RUN  = 1'b1
    } pk_state_e;

    function automatic int unsigned slice_bits(input int unsigned width, input int unsigned chains);
        return width / chains;
    endfunction

endpackage

// File: rtl/resp_packer_seq.sv
module resp_packer_seq
    import resp_packer_pkg::*;
#(
    parameter int unsigned P        = 3,
    parameter int unsigned SCAN_LEN = 8,
    localparam int unsigned CW      = $clog2(P + 1),
    localparam int unsigned LW      = $clog2(SCAN_LEN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          slot_free_i,
    output logic          busy_o,
    output logic          shift_o,
    output logic          word_done_o,
    output logic          first_o,
    output logic [CW-1:0] bit_idx_o
);

    typedef struct packed {
        pk_state_e   state;
        logic [CW-1:0] bit_cnt;
        logic [LW-1:0] bits_left;
        logic          first;
    } seq_t;

    seq_t seq_d, seq_q;
    logic closes_word;

    always_comb begin
        seq_d       = seq_q;
        closes_word = (seq_q.bit_cnt == CW'(P - 1)) || (seq_q.bits_left == LW'(1));
        shift_o     = (seq_q.state == PK_RUN) && (!closes_word || slot_free_i);
        word_done_o = shift_o && closes_word;

        if (seq_q.state == PK_IDLE) begin
            if (start_i) begin
                seq_d.state     = PK_RUN;
                seq_d.bit_cnt   = '0;
                seq_d.bits_left = LW'(SCAN_LEN);
                seq_d.first     = 1'b1;
            end
        end else if (shift_o) begin
            seq_d.bits_left = seq_q.bits_left - LW'(1);
            if (closes_word) begin
                seq_d.bit_cnt = '0;
                seq_d.first   = 1'b0;
                if (seq_q.bits_left == LW'(1)) begin
                    seq_d.state = PK_IDLE;
                end
            end else begin
                seq_d.bit_cnt = seq_q.bit_cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: PK_IDLE, bit_cnt: '0, bits_left: '0, first: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o    = (seq_q.state == PK_RUN);
    assign first_o   = seq_q.first;
    assign bit_idx_o = seq_q.bit_cnt;

    AST_LEFT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.bits_left <= LW'(SCAN_LEN)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.bit_cnt < CW'(P)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !shift_o); // R8

endmodule

// File: rtl/resp_packer_collect.sv
module resp_packer_collect #(
    parameter int unsigned K  = 10,
    parameter int unsigned P  = 3,
    localparam int unsigned CW = $clog2(P + 1),
    localparam int unsigned SW = K * P
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          shift_i,
    input  logic          word_done_i,
    input  logic [CW-1:0] bit_idx_i,
    input  logic [K-1:0]  chain_i,
    output logic [SW-1:0] slices_o
);

    typedef struct packed {
        logic [SW-1:0] col;
    } col_t;

    col_t col_d, col_q;
    logic [SW-1:0] merged;

    for (genvar c = 0; c < K; c++) begin : g_chain
        for (genvar j = 0; j < P; j++) begin : g_bit
            always_comb begin
                merged[c*P + j] = col_q.col[c*P + j];
                if (shift_i && (bit_idx_i == CW'(j))) begin
                    merged[c*P + j] = chain_i[c];
                end
            end
        end
    end

    always_comb begin
        col_d.col = word_done_i ? '0 : merged;
        slices_o  = merged;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    AST_FRESH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_done_i |=> (col_q.col == '0)); // R5

endmodule

// File: rtl/resp_packer_outreg.sv
module resp_packer_outreg #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         ready_i,
    output logic         slot_free_o,
    output logic         valid_o,
    output logic [W-1:0] data_o
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        slot_free_o = !out_q.valid || ready_i;
        if (out_q.valid && ready_i) begin
            out_d.valid = 1'b0;
        end
        if (load_i) begin
            out_d.valid = 1'b1;
            out_d.data  = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '{valid: 1'b0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.valid;
    assign data_o  = out_q.data;

    AST_HOLD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R7

    AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && valid_o) |-> ready_i); // R6

endmodule

// File: rtl/resp_packer.sv
module resp_packer
    import resp_packer_pkg::*;
#(
    parameter int unsigned W        = 32,
    parameter int unsigned K        = 10,
    parameter int unsigned SCAN_LEN = 8,
    localparam int unsigned P       = slice_bits(W, K),
    localparam int unsigned SW      = K * P,
    localparam int unsigned REM     = W - SW,
    localparam int unsigned RW      = (REM > 0) ? REM : 1,
    localparam int unsigned CW      = $clog2(P + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [RW-1:0] rem_i,
    input  logic [K-1:0]  chain_so_i,
    output logic          shift_o,
    output logic [W-1:0]  word_o,
    output logic          word_valid_o,
    input  logic          word_ready_i,
    output logic          busy_o
);

    typedef struct packed {
        logic [RW-1:0] rem;
    } rem_t;

    rem_t rem_d, rem_q;

    logic          slot_free;
    logic          word_done;
    logic          first_word;
    logic [CW-1:0] bit_idx;
    logic [SW-1:0] slices;
    logic [W-1:0]  word_next;

    resp_packer_seq #(.P(P), .SCAN_LEN(SCAN_LEN)) seq_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .slot_free_i (slot_free),
        .busy_o      (busy_o),
        .shift_o     (shift_o),
        .word_done_o (word_done),
        .first_o     (first_word),
        .bit_idx_o   (bit_idx)
    );

    resp_packer_collect #(.K(K), .P(P)) collect_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .shift_i     (shift_o),
        .word_done_i (word_done),
        .bit_idx_i   (bit_idx),
        .chain_i     (chain_so_i),
        .slices_o    (slices)
    );

    always_comb begin
        rem_d = rem_q;
        if (!busy_o && start_i) begin
            rem_d.rem = rem_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    if (REM > 0) begin : g_rem
        assign word_next = {(first_word ? rem_q.rem : {RW{1'b0}}), slices};
    end else begin : g_norem
        logic unused_rem;
        assign unused_rem = ^rem_q.rem;
        assign word_next  = slices;
    end

    resp_packer_outreg #(.W(W)) outreg_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (word_done),
        .data_i      (word_next),
        .ready_i     (word_ready_i),
        .slot_free_o (slot_free),
        .valid_o     (word_valid_o),
        .data_o      (word_o)
    );

    AST_SHIFT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_o |-> busy_o); // R10

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(rem_q)); // R8

endmodule

// File: tb/resp_packer_tb.sv
module resp_packer_tb_top;

    localparam int W  = 32;
    localparam int K  = 10;
    localparam int SL = 8;
    localparam int P  = W / K;
    localparam int SW = K * P;
    localparam int REM = W - SW;
    localparam int NW = (SL + P - 1) / P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [REM-1:0] rem_i = '0;
    logic [K-1:0] chain_so_i = '0;
    logic shift_o;
    logic [W-1:0] word_o;
    logic word_valid_o;
    logic word_ready_i = 1'b0;
    logic busy_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    resp_packer #(.W(W), .K(K), .SCAN_LEN(SL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rem_i(rem_i),
        .chain_so_i(chain_so_i), .shift_o(shift_o), .word_o(word_o),
        .word_valid_o(word_valid_o), .word_ready_i(word_ready_i), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_pattern(input int mode, input int ready_pct, input bit spurious);
        logic [K-1:0] bits [SL];
        logic [W-1:0] exp_q [$];
        logic [REM-1:0] rem;
        logic [W-1:0] held;
        bit hold_pending;
        int idx;
        int got;
        int loop_n;
        for (int b = 0; b < SL; b++) begin
            case (mode)
                0: bits[b] = '1;
                1: bits[b] = '0;
                2: bits[b] = (b % 2 == 0) ? K'(10'h155) : K'(10'h2AA);
                default: bits[b] = K'($urandom);
            endcase
        end
        rem = REM'($urandom) | REM'(1);
        for (int w = 0; w < NW; w++) begin
            logic [W-1:0] e;
            e = '0;
            for (int c = 0; c < K; c++) begin
                for (int j = 0; j < P; j++) begin
                    if (w * P + j < SL) e[c*P + j] = bits[w*P + j][c];
                end
            end
            if (w == 0) e[W-1:SW] = rem;
            exp_q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b1;
        rem_i = rem;
        @(negedge clk);
        start_i = 1'b0;
        rem_i = ~rem;
        idx = 0;
        got = 0;
        loop_n = 0;
        hold_pending = 1'b0;
        while (got < NW && !timed_out) begin
            chain_so_i = (idx < SL) ? bits[idx] : K'($urandom);
            word_ready_i = ($urandom_range(99) < ready_pct);
            if (spurious && loop_n == 2) begin
                start_i = 1'b1;
                rem_i = REM'($urandom);
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (hold_pending) begin
                check(word_valid_o && word_o == held, "R7 hold", word_o, held);
            end
            hold_pending = word_valid_o && !word_ready_i;
            held = word_o;
            if (word_valid_o && word_ready_i) begin
                logic [W-1:0] e;
                e = exp_q[got];
                check(word_o[SW-1:0] == e[SW-1:0], "R1 slices", word_o, e);
                if (got == 0) check(word_o[W-1:SW] == e[W-1:SW], "R3 remainder first", word_o, e);
                else check(word_o[W-1:SW] == '0, "R4 remainder idle", word_o, e);
                if (got == NW - 1 && (SL % P) != 0) begin
                    logic [W-1:0] pad;
                    pad = '0;
                    for (int c = 0; c < K; c++)
                        for (int j = SL % P; j < P; j++) pad[c*P + j] = 1'b1;
                    check((word_o & pad) == '0, "R5 padding", word_o & pad, '0);
                end
                got++;
            end
            if (shift_o) idx++;
            loop_n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        word_ready_i = 1'b0;
        check(idx == SL, "R6 shift count", W'(idx), W'(SL));
        check(got == NW, "R2 word count", W'(got), W'(NW));
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!shift_o && !busy_o, "R8 quiet after pattern", W'({shift_o, busy_o}), '0);
            check(!shift_o || busy_o, "R10 shift only busy", W'(shift_o), '0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) timed_out = 1'b1;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!word_valid_o && !shift_o && !busy_o, "R9 reset", W'({word_valid_o, shift_o, busy_o}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!word_valid_o && !shift_o && !busy_o, "R9 after reset", W'({word_valid_o, shift_o, busy_o}), '0);
        run_pattern(0, 100, 1'b0);
        run_pattern(1, 100, 1'b0);
        run_pattern(2, 50, 1'b0);
        run_pattern(3, 30, 1'b1);
        for (int t = 0; t < 20 && !timed_out; t++) begin
            run_pattern(3, (t % 2 == 0) ? 15 : 80, (t % 3 == 0));
        end
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule